// File: doc/BRIEF.md
# Guarded Cache Prefetch Issue Filter

This block sits between an instruction issue stage and a data cache miss path. It takes a prefetch hint made of a base register value, a compact signed displacement field and an optional guard value. It forms the target byte address, rounds it down to the start of its cache block, and then decides whether a block fill request should go to memory.

A prefetch is only a hint, so the block never stalls the issuer on a drop and never returns a result. A hint is discarded when its guard is false, when the tag lookup reports the block as already resident, or when the miss path already holds its limit of outstanding misses. A hint that survives becomes a fill request. The fill request is held with a valid/ready handshake until memory takes it. Each discarded hint produces a one-cycle pulse with a reason code.

Top module: `pf_hint_filter`

## Requirements
- R1: The lookup address `lk_addr` equals (`req_base` + sign-extended `req_disp` × 4) with the low log2(BLK_BYTES) bits cleared, wrapping modulo 2^AW. The 7-bit displacement field spans -256 to 252 bytes in steps of 4. With 64-byte blocks, base 0xabcd and field 3 give 0xabc0, and base 0xabff and field 1 give 0xac00.
- R2: When `req_has_guard` is 1, only bit 0 of `req_guard` counts. A 0 in bit 0 drops the hint with reason code 1. When `req_has_guard` is 0, the hint behaves as if guarded true.
- R3: A hint that passes its guard and sees `lk_hit`=1 is dropped with reason code 2. The guard check takes priority over the hit check.
- R4: A hint that passes its guard, misses in the lookup, and sees `miss_cnt` >= MAX_MISS (default 2) is dropped with reason code 3 and is not queued.
- R5: A hint that passes all three checks raises `fill_valid` in the cycle after acceptance, with `fill_addr` equal to the R1 aligned address.
- R6: While `fill_valid` is 1 and `fill_ready` is 0, `fill_valid` and `fill_addr` hold. `req_ready` is 0 exactly while `fill_valid` is 1. A cycle with `fill_ready`=1 completes the fill, so `fill_valid` is 0 in the next cycle.
- R7: Every dropped hint raises `drop_pulse` for one cycle, the cycle after acceptance, with `drop_why` holding the reason. An issued hint raises no pulse.
- R8: After reset, `fill_valid` and `drop_pulse` are 0 and `req_ready` is 1.
- R9: A cycle with `req_valid`=0 raises neither `drop_pulse` nor `fill_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Prefetch hint present |
| req_ready | output | 1 | Hint can be accepted this cycle |
| req_base | input | AW | Base register value |
| req_disp | input | 7 | Signed displacement field, in units of 4 bytes |
| req_has_guard | input | 1 | Guard operand present |
| req_guard | input | GW | Guard register value; only bit 0 is used |
| lk_addr | output | AW | Aligned block address sent to the tag lookup |
| lk_hit | input | 1 | Same-cycle lookup result: block resident |
| miss_cnt | input | CW | Misses currently outstanding |
| fill_valid | output | 1 | Fill request pending |
| fill_addr | output | AW | Aligned block address of the pending fill |
| fill_ready | input | 1 | Memory accepts the fill request |
| drop_pulse | output | 1 | A hint was discarded last cycle |
| drop_why | output | 2 | Reason: 1 guard, 2 hit, 3 busy |

## Verification
The assertions assume that the tag lookup answers `lk_hit` in the same cycle for the address on `lk_addr`, and that `fill_ready` is meaningful only while a fill is pending. The stimulus meets both assumptions. The bench derives `lk_hit` from its own set of resident blocks, keyed on the aligned address it computes. It raises `fill_ready` only after it has seen `fill_valid`. `miss_cnt` comes from the bench's model of outstanding misses and is held steady around every accepted hint.

// File: rtl/pf_hint_filter.sv
module pf_hint_filter #(
  parameter int AW        = 32,
  parameter int GW        = 32,
  parameter int BLK_BYTES = 64,
  parameter int CW        = 2,
  parameter int MAX_MISS  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_base,
  input  logic [6:0]    req_disp,
  input  logic          req_has_guard,
  input  logic [GW-1:0] req_guard,
  output logic [AW-1:0] lk_addr,
  input  logic          lk_hit,
  input  logic [CW-1:0] miss_cnt,
  output logic          fill_valid,
  output logic [AW-1:0] fill_addr,
  input  logic          fill_ready,
  output logic          drop_pulse,
  output logic [1:0]    drop_why
);
  localparam int OW = $clog2(BLK_BYTES);

  logic [AW-1:0] disp_bytes, eff_addr;
  logic          accept, guard_ok, busy;
  logic [1:0]    why;
  logic          unused_guard_bits;

  assign unused_guard_bits = ^req_guard[GW-1:1];

  assign disp_bytes = {{(AW-9){req_disp[6]}}, req_disp, 2'b00};
  assign eff_addr   = req_base + disp_bytes;
  assign lk_addr    = {eff_addr[AW-1:OW], {OW{1'b0}}};

  assign req_ready = !fill_valid;
  assign accept    = req_valid && req_ready;
  assign guard_ok  = !req_has_guard || req_guard[0];
  assign busy      = miss_cnt >= CW'(MAX_MISS);

  always_comb begin
    if (!guard_ok)   why = 2'd1;
    else if (lk_hit) why = 2'd2;
    else if (busy)   why = 2'd3;
    else             why = 2'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_valid <= 1'b0;
      fill_addr  <= '0;
      drop_pulse <= 1'b0;
      drop_why   <= 2'd0;
    end else begin
      drop_pulse <= accept && (why != 2'd0);
      if (accept) drop_why <= why;
      if (fill_valid && fill_ready) fill_valid <= 1'b0;
      else if (accept && why == 2'd0) begin
        fill_valid <= 1'b1;
        fill_addr  <= lk_addr;
      end
    end
  end
endmodule

// File: rtl/pf_hint_filter_chk.sv
module pf_hint_filter_chk #(
  parameter int AW        = 32,
  parameter int BLK_BYTES = 64,
  parameter int CW        = 2,
  parameter int MAX_MISS  = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_has_guard,
  input logic          guard_bit,
  input logic          lk_hit,
  input logic [CW-1:0] miss_cnt,
  input logic          fill_valid,
  input logic [AW-1:0] fill_addr,
  input logic          fill_ready,
  input logic          drop_pulse,
  input logic [1:0]    drop_why
);
  localparam int OW = $clog2(BLK_BYTES);
  logic acc_ok;
  assign acc_ok = req_valid && req_ready && (!req_has_guard || guard_bit);

  // R2
  guard_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_has_guard && !guard_bit) |=> (drop_pulse && drop_why == 2'd1 && !fill_valid));
  // R3
  hit_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && lk_hit) |=> (drop_pulse && drop_why == 2'd2 && !fill_valid));
  // R4
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && !lk_hit && miss_cnt >= CW'(MAX_MISS)) |=> (drop_pulse && drop_why == 2'd3 && !fill_valid));
  // R5
  issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && !lk_hit && miss_cnt < CW'(MAX_MISS)) |=> (fill_valid && !drop_pulse));
  // R6
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !fill_ready) |=> (fill_valid && $stable(fill_addr)));
  // R6
  ready_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> !req_ready);
  // R1
  fill_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> (fill_addr[OW-1:0] == '0));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !fill_valid) |=> (!drop_pulse && !fill_valid));
endmodule

bind pf_hint_filter pf_hint_filter_chk #(.AW(AW), .BLK_BYTES(BLK_BYTES), .CW(CW), .MAX_MISS(MAX_MISS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_has_guard(req_has_guard), .guard_bit(req_guard[0]), .lk_hit(lk_hit),
  .miss_cnt(miss_cnt), .fill_valid(fill_valid), .fill_addr(fill_addr),
  .fill_ready(fill_ready), .drop_pulse(drop_pulse), .drop_why(drop_why)
);

// File: tb/test_pf_hint_filter.sv
module test_pf_hint_filter;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int NRES = 16;

  logic          clk = 0, rst_n = 0;
  logic          req_valid = 0, req_has_guard = 0, lk_hit = 0, fill_ready = 0;
  logic [AW-1:0] req_base = '0;
  logic [6:0]    req_disp = '0;
  logic [31:0]   req_guard = '0;
  logic [1:0]    miss_cnt = '0;
  logic          req_ready, fill_valid, drop_pulse;
  logic [AW-1:0] lk_addr, fill_addr;
  logic [1:0]    drop_why;

  int total = 0, bad = 0;
  logic [AW-1:0] resident [NRES];
  int res_ptr = 0;
  int outst = 0;
  bit done = 0;

  pf_hint_filter i_pf_hint_filter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_base(req_base), .req_disp(req_disp), .req_has_guard(req_has_guard),
    .req_guard(req_guard), .lk_addr(lk_addr), .lk_hit(lk_hit), .miss_cnt(miss_cnt),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_ready(fill_ready),
    .drop_pulse(drop_pulse), .drop_why(drop_why)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, logic [6:0] d);
    logic [AW-1:0] s;
    s = b + {{(AW-9){d[6]}}, d, 2'b00};
    return {s[AW-1:6], 6'b0};
  endfunction

  function automatic logic [1:0] exp_code(bit hg, logic [31:0] g, bit hit, int mc);
    if (hg && !g[0]) return 2'd1;
    if (hit) return 2'd2;
    if (mc >= 2) return 2'd3;
    return 2'd0;
  endfunction

  function automatic bit is_res(logic [AW-1:0] a);
    for (int i = 0; i < NRES; i++) if (resident[i] == a) return 1;
    return 0;
  endfunction

  task automatic chk(bit ok, string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one hint; hit_mode: 0 use model, 1 force hit, 2 force miss
  task automatic do_req(logic [AW-1:0] b, logic [6:0] d, bit hg, logic [31:0] g, int hit_mode, int mc);
    logic [AW-1:0] ea;
    bit hit;
    logic [1:0] code;
    int waitc;
    @(negedge clk);
    ea = exp_addr(b, d);
    hit = (hit_mode == 1) ? 1'b1 : (hit_mode == 2) ? 1'b0 : is_res(ea);
    req_base = b; req_disp = d; req_has_guard = hg; req_guard = g;
    lk_hit = hit; miss_cnt = 2'(mc); req_valid = 1;
    #1;
    chk(lk_addr == ea, "R1 lookup address", lk_addr, ea);
    chk(req_ready == 1, "R6 ready when idle", AW'(req_ready), 1);
    code = exp_code(hg, g, hit, mc);
    @(negedge clk);
    req_valid = 0; lk_hit = 0;
    if (code != 0) begin
      chk(drop_pulse == 1, "R7 drop pulse", AW'(drop_pulse), 1);
      chk(drop_why == code, code == 1 ? "R2 guard reason" : code == 2 ? "R3 hit reason" : "R4 busy reason",
          AW'(drop_why), AW'(code));
      chk(fill_valid == 0, "R4 no fill on drop", AW'(fill_valid), 0);
      @(negedge clk);
      chk(drop_pulse == 0, "R7 pulse one cycle", AW'(drop_pulse), 0);
    end else begin
      chk(fill_valid == 1 && fill_addr == ea, "R5 fill issued", fill_addr, ea);
      chk(drop_pulse == 0, "R7 no pulse on issue", AW'(drop_pulse), 0);
      chk(req_ready == 0, "R6 ready low while pending", AW'(req_ready), 0);
      waitc = $urandom_range(0, 3);
      for (int k = 0; k < waitc; k++) begin
        @(negedge clk);
        chk(fill_valid == 1 && fill_addr == ea, "R6 fill held", fill_addr, ea);
      end
      fill_ready = 1;
      @(negedge clk);
      fill_ready = 0;
      chk(fill_valid == 0 && req_ready == 1, "R6 fill completes", AW'(fill_valid), 0);
      resident[res_ptr] = ea;
      res_ptr = (res_ptr + 1) % NRES;
      if (outst < 3) outst++;
    end
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          total++; bad++;
          $display("FAIL watchdog actual=hung expected=done");
          $display("test done: total=%0d bad=%0d", total, bad);
          $finish;
        end
      end
    join_none
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < NRES; i++) resident[i] = '1;
    repeat (3) @(negedge clk);
    chk(fill_valid == 0 && drop_pulse == 0 && req_ready == 1, "R8 reset state", AW'(fill_valid), 0);
    rst_n = 1;

    // directed
    do_req(32'h0000_abcd, 7'd3, 0, 0, 2, 0);
    do_req(32'h0000_abff, 7'd1, 1, 32'h1, 2, 0);
    do_req(32'h0000_1000, 7'h40, 0, 0, 2, 0);
    do_req(32'h0000_1000, 7'h3f, 0, 0, 2, 0);
    do_req(32'h0000_0010, 7'h40, 0, 0, 2, 0);
    do_req(32'h0000_2000, 7'd0, 1, 32'h2, 2, 0);
    do_req(32'h0000_2000, 7'd0, 1, 32'hffff_fffe, 2, 0);
    do_req(32'h0000_2000, 7'd0, 1, 32'h3, 2, 0);
    do_req(32'h0000_3000, 7'd0, 1, 32'h0, 1, 3);
    do_req(32'h0000_3000, 7'd0, 0, 0, 1, 3);
    do_req(32'h0000_3000, 7'd0, 0, 0, 2, 2);
    do_req(32'h0000_3000, 7'd0, 0, 0, 2, 1);

    // R9 idle cycles with noisy inputs
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      req_base = $urandom; lk_hit = $urandom_range(0, 1); miss_cnt = 0;
      @(negedge clk);
      chk(drop_pulse == 0 && fill_valid == 0, "R9 idle no effect", AW'(drop_pulse), 0);
    end

    outst = 0;
    for (int n = 0; n < 600; n++) begin
      if (outst > 0 && $urandom_range(0, 2) == 0) outst--;
      do_req(32'h0000_4000 + AW'($urandom_range(0, 1023)), 7'($urandom),
             1'($urandom_range(0, 1)), $urandom, 0, outst);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule